// File: doc/BRIEF.md
# Master Interrupt Routing Controller

This block gathers up to 32 level-sensitive system interrupt lines, captures them each cycle into a pending register, and screens them through a software-controlled disable register. Every source that is both pending and enabled is translated into a processor interrupt level through a fixed, non-linear source-to-level table. The union of those levels is presented as a 16-bit level vector to exactly one processor: the one software has chosen as the current interrupt target. All other processors see an all-zero vector.

Software reaches the block through a five-word register window with separate read and write strobes and a word index. Enabling and disabling are done through a write-one-to-clear / write-one-to-set pair acting on the disable register, so individual sources can be switched without a read-modify-write. The top bit of the disable register is a global kill switch that silences delivery to every processor; its state is also exported so that downstream per-processor logic can apply it to its own private sources.

Top module: `mir_top`

## Requirements
- R1: After reset the pending register reads 0, the disable register reads 0 through word 1, the target reads 0 through word 4, every level output is 0 and the master-off output is 0; internally the disable register holds 0x0FA2007F.
- R2: The pending register takes the value of the source inputs at each rising clock edge; reading word 0 (index 0) returns it with bit 31 forced to 0.
- R3: Only bits in the writable mask 0xF05DFF80 can change in the disable register; bits outside it stay set for ever, so those sources never raise a level, and word 1 (index 1) reads the disable register ANDed with that mask.
- R4: Writing word 2 (index 2) clears the written bits in the disable register (enables those sources) and writing word 3 (index 3) sets them; neither write changes the pending register.
- R5: Writing word 4 (index 4) sets the target to the written value ANDed with (NUM_CPU-1); reading word 4 returns the target.
- R6: Source bits 0..31 map in order to levels 2,3,5,7,9,11,13,2,3,5,7,9,11,13,12,12,6,13,4,10,8,9,11,0,0,0,0,15,15,15,15,0; a pending enabled source sets bit (level) of the target's 16-bit vector, and a source of level 0 sets nothing, so bit 0 is always 0.
- R7: Only the target processor's vector, at bits [16*t+15:16*t] of the level output, is non-zero; every other processor's vector is 0.
- R8: While bit 31 of the disable register is set, every level output is 0, and the master-off output equals that bit.
- R9: A level shared by several sources stays asserted while any enabled source mapped to it is pending.
- R10: Reads of indices 5 to 7 return 0, reads with the read strobe low return 0, and writes to indices 0, 1 and 5 to 7 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Level-sensitive system interrupt sources |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 3 | Word index into the register window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational, 0 when no read |
| cpu_lvl_o | output | 16*NUM_CPU | Per-processor level vectors, processor c at bits [16c+15:16c] |
| master_off_o | output | 1 | Global delivery kill bit (disable register bit 31) |

## Verification
The assertions assume the source lines and register strobes are clean, settled values at each rising edge and that reset is held for at least one edge before any access; the bench changes every input only at the falling edge and holds reset for several cycles. They also assume NUM_CPU is a power of two, so the target mask selects every processor, which the bench keeps by using the default of four. Read and write strobes are never raised in the same cycle by the bench, so no read observes a half-applied write.

// File: rtl/mir_pkg.sv
package mir_pkg;

  localparam int SRC_N = 32;
  localparam int LVL_N = 16;
  localparam int LVL_W = $clog2(LVL_N);
  localparam int IDX_W = 3;

  localparam logic [IDX_W-1:0] W_PEND   = 3'd0;
  localparam logic [IDX_W-1:0] W_DIS    = 3'd1;
  localparam logic [IDX_W-1:0] W_ENABLE = 3'd2;
  localparam logic [IDX_W-1:0] W_KILL   = 3'd3;
  localparam logic [IDX_W-1:0] W_TARGET = 3'd4;

  localparam logic [SRC_N-1:0] FIXED_OFF  = 32'h0FA2_007F;
  localparam logic [SRC_N-1:0] WRITE_MASK = ~FIXED_OFF;
  localparam int               KILL_BIT   = SRC_N - 1;

  // Fixed source-to-level translation; level 0 means "never delivered".
  function automatic logic [LVL_W-1:0] src_level(input int unsigned idx);
    logic [LVL_W-1:0] l;
    case (idx)
      0, 7:                 l = 4'd2;
      1, 8:                 l = 4'd3;
      2, 9:                 l = 4'd5;
      3, 10:                l = 4'd7;
      4, 11, 21:            l = 4'd9;
      5, 12, 22:            l = 4'd11;
      6, 13, 17:            l = 4'd13;
      14, 15:               l = 4'd12;
      16:                   l = 4'd6;
      18:                   l = 4'd4;
      19:                   l = 4'd10;
      20:                   l = 4'd8;
      27, 28, 29, 30:       l = 4'd15;
      default:              l = 4'd0;
    endcase
    return l;
  endfunction

  // One-hot level vector for a source; level 0 yields no bit.
  function automatic logic [LVL_N-1:0] src_onehot(input int unsigned idx);
    logic [LVL_W-1:0] l;
    l = src_level(idx);
    return (l == '0) ? '0 : (LVL_N'(1) << l);
  endfunction

endpackage

// File: rtl/mir_regs.sv
module mir_regs
  import mir_pkg::*;
#(
  parameter int NUM_CPU = 4,
  localparam int TGT_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] src_i,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [SRC_N-1:0] wdata_i,
  output logic [SRC_N-1:0] pend_q,
  output logic [SRC_N-1:0] dis_q,
  output logic [TGT_W-1:0] tgt_q
);

  logic [SRC_N-1:0] wmask;
  logic             do_enable;
  logic             do_kill;
  logic             do_target;
  logic [SRC_N-1:0] tgt_full;

  assign wmask     = wdata_i & WRITE_MASK;
  assign do_enable = wr_i && (idx_i == W_ENABLE);
  assign do_kill   = wr_i && (idx_i == W_KILL);
  assign do_target = wr_i && (idx_i == W_TARGET);
  assign tgt_full  = wdata_i & SRC_N'(NUM_CPU - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q <= src_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_q <= FIXED_OFF;
    end else if (do_enable) begin
      dis_q <= dis_q & ~wmask;
    end else if (do_kill) begin
      dis_q <= dis_q | wmask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= '0;
    end else if (do_target) begin
      tgt_q <= tgt_full[TGT_W-1:0];
    end
  end

endmodule

// File: rtl/mir_level_map.sv
module mir_level_map
  import mir_pkg::*;
(
  input  logic [SRC_N-1:0] active_i,
  output logic [LVL_N-1:0] lvl_o
);

  logic [LVL_N-1:0] contrib [SRC_N];

  for (genvar s = 0; s < SRC_N; s++) begin : g_src
    localparam logic [LVL_N-1:0] HOT = src_onehot(s);
    assign contrib[s] = active_i[s] ? HOT : '0;
  end

  always_comb begin
    lvl_o = '0;
    for (int s = 0; s < SRC_N; s++) begin
      lvl_o = lvl_o | contrib[s];
    end
  end

endmodule

// File: rtl/mir_route.sv
module mir_route
  import mir_pkg::*;
#(
  parameter int NUM_CPU = 4,
  localparam int TGT_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                     deliver_i,
  input  logic [TGT_W-1:0]         tgt_i,
  input  logic [LVL_N-1:0]         lvl_i,
  output logic [NUM_CPU*LVL_N-1:0] cpu_lvl_o
);

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic sel;
    assign sel = deliver_i && (tgt_i == TGT_W'(c));
    assign cpu_lvl_o[c*LVL_N +: LVL_N] = sel ? lvl_i : '0;
  end

endmodule

// File: rtl/mir_top.sv
module mir_top
  import mir_pkg::*;
#(
  parameter int NUM_CPU = 4,
  localparam int TGT_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [31:0]              src_i,
  input  logic                     reg_rd,
  input  logic                     reg_wr,
  input  logic [2:0]               reg_idx,
  input  logic [31:0]              reg_wdata,
  output logic [31:0]              reg_rdata,
  output logic [NUM_CPU*16-1:0]    cpu_lvl_o,
  output logic                     master_off_o
);

  logic [SRC_N-1:0] pend_q;
  logic [SRC_N-1:0] dis_q;
  logic [TGT_W-1:0] tgt_q;
  logic [SRC_N-1:0] active;
  logic [LVL_N-1:0] lvl;
  logic             deliver;

  mir_regs #(.NUM_CPU(NUM_CPU)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .src_i  (src_i),
    .wr_i   (reg_wr),
    .idx_i  (reg_idx),
    .wdata_i(reg_wdata),
    .pend_q (pend_q),
    .dis_q  (dis_q),
    .tgt_q  (tgt_q)
  );

  assign active       = pend_q & ~dis_q;
  assign master_off_o = dis_q[KILL_BIT];
  assign deliver      = (active != '0) && !master_off_o;

  mir_level_map u_map (
    .active_i(active),
    .lvl_o   (lvl)
  );

  mir_route #(.NUM_CPU(NUM_CPU)) u_route (
    .deliver_i(deliver),
    .tgt_i    (tgt_q),
    .lvl_i    (lvl),
    .cpu_lvl_o(cpu_lvl_o)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (reg_idx)
        W_PEND:   reg_rdata = pend_q & ~(SRC_N'(1) << KILL_BIT);
        W_DIS:    reg_rdata = dis_q & WRITE_MASK;
        W_TARGET: reg_rdata = SRC_N'(tgt_q);
        default:  reg_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/mir_checker.sv
module mir_checker
  import mir_pkg::*;
#(
  parameter int NUM_CPU = 4,
  localparam int TGT_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [31:0]              src_i,
  input logic                     reg_wr,
  input logic [2:0]               reg_idx,
  input logic [31:0]              reg_wdata,
  input logic [SRC_N-1:0]         pend_q,
  input logic [SRC_N-1:0]         dis_q,
  input logic [TGT_W-1:0]         tgt_q,
  input logic [NUM_CPU*16-1:0]    cpu_lvl_o,
  input logic                     master_off_o
);

  logic             past_ok;
  logic [NUM_CPU-1:0] busy;
  logic             any_lvl0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_c
    assign busy[c] = cpu_lvl_o[c*16 +: 16] != '0;
  end

  always_comb begin
    any_lvl0 = 1'b0;
    for (int c = 0; c < NUM_CPU; c++) any_lvl0 = any_lvl0 | cpu_lvl_o[c*16];
  end

  AST_PEND_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> pend_q == $past(src_i)); // R2

  AST_FIXED_BITS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_q & FIXED_OFF) == FIXED_OFF); // R3

  AST_ENABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && reg_wr && reg_idx == W_ENABLE) |=>
      (dis_q & ($past(reg_wdata) & WRITE_MASK)) == '0); // R4

  AST_KILL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && reg_wr && reg_idx == W_KILL) |=>
      (dis_q & ($past(reg_wdata) & WRITE_MASK)) == ($past(reg_wdata) & WRITE_MASK)); // R4

  AST_LEVEL0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !any_lvl0); // R6

  AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(busy) && ((busy == '0) || busy[tgt_q])); // R7

  AST_KILL_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
    master_off_o |-> busy == '0); // R8

  AST_IGNORED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && reg_wr && (reg_idx < W_ENABLE || reg_idx > W_TARGET)) |=>
      $stable(dis_q) && $stable(tgt_q)); // R10

endmodule

bind mir_top mir_checker #(.NUM_CPU(NUM_CPU)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .src_i       (src_i),
  .reg_wr      (reg_wr),
  .reg_idx     (reg_idx),
  .reg_wdata   (reg_wdata),
  .pend_q      (pend_q),
  .dis_q       (dis_q),
  .tgt_q       (tgt_q),
  .cpu_lvl_o   (cpu_lvl_o),
  .master_off_o(master_off_o)
);

// File: tb/mir_top_tb.sv
module mir_top_tb;

  localparam int CLK_P   = 10;
  localparam int NCPU    = 4;
  localparam int LV [32] = '{2,3,5,7,9,11,13,2,3,5,7,9,11,13,12,12,
                             6,13,4,10,8,9,11,0,0,0,0,15,15,15,15,0};
  localparam logic [31:0] STUCK = 32'h0FA2_007F;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [31:0]       src_i = '0;
  logic              reg_rd = 1'b0;
  logic              reg_wr = 1'b0;
  logic [2:0]        reg_idx = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic [NCPU*16-1:0] cpu_lvl_o;
  logic              master_off_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench-side model state
  logic [31:0] m_dis;
  int          m_tgt;

  always #(CLK_P/2) clk = ~clk;

  mir_top #(.NUM_CPU(NCPU)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_lvl_o(cpu_lvl_o), .master_off_o(master_off_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_idx = 3'(idx); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
    if (idx == 2) m_dis = m_dis & ~(d & ~STUCK);
    if (idx == 3) m_dis = m_dis | (d & ~STUCK);
    if (idx == 4) m_tgt = int'(d & 32'(NCPU - 1));
  endtask

  task automatic rd(input int idx, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_idx = 3'(idx);
    #1 d = reg_rdata;
    reg_rd = 1'b0;
  endtask

  task automatic drive_src(input logic [31:0] v);
    @(negedge clk);
    src_i = v;
    @(negedge clk);
  endtask

  function automatic logic [NCPU*16-1:0] model_out();
    logic [15:0] l = '0;
    logic [31:0] act = src_i & ~m_dis;
    logic [NCPU*16-1:0] o = '0;
    for (int j = 0; j < 32; j++)
      if (act[j] && LV[j] != 0) l[LV[j]] = 1'b1;
    if (!m_dis[31] && act != 0) o[m_tgt*16 +: 16] = l;
    return o;
  endfunction

  task automatic check_out(input string req);
    chk(req, 64'(cpu_lvl_o), 64'(model_out()));
    chk({req, " kill"}, 64'(master_off_o), 64'(m_dis[31]));
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(0, d); chk("R1 pend", d, 0);
    rd(1, d); chk("R1 dis", d, 0);
    rd(4, d); chk("R1 tgt", d, 0);
    chk("R1 out", 64'(cpu_lvl_o), 0);
    chk("R1 kill", 64'(master_off_o), 0);
  endtask

  task automatic t_pending();
    logic [31:0] d;
    drive_src(32'hFFFF_FFFF);
    rd(0, d); chk("R2 pend bit31 hidden", d, 32'h7FFF_FFFF);
    check_out("R2 all");
    drive_src(32'h0001_2340);
    rd(0, d); chk("R2 pend pattern", d, 32'h0001_2340);
    check_out("R2 pattern");
  endtask

  task automatic t_masks();
    logic [31:0] d;
    drive_src(32'hA5A5_A5A5);
    wr(2, 32'hFFFF_FFFF);
    rd(1, d); chk("R4 enable all", d, 0);
    rd(0, d); chk("R4 pend unchanged", d, 32'h25A5_A5A5);
    check_out("R4 enabled");
    wr(3, 32'hFFFF_FFFF);
    rd(1, d); chk("R3 masked dis read", d, 32'hF05D_FF80);
    rd(0, d); chk("R4 pend unchanged kill", d, 32'h25A5_A5A5);
    check_out("R8 all off");
    wr(2, 32'hFFFF_FFFF);
  endtask

  task automatic t_table();
    for (int j = 0; j < 32; j++) begin
      drive_src(32'h1 << j);
      check_out($sformatf("R6 src%0d", j));
    end
    drive_src(32'h0F00_0001);
    chk("R3 stuck sources silent", 64'(cpu_lvl_o), 0);
  endtask

  task automatic t_shared();
    drive_src(32'h0000_C000);
    chk("R9 both", 64'(cpu_lvl_o[15:0]), 64'(16'h1000));
    drive_src(32'h0000_8000);
    chk("R9 one left", 64'(cpu_lvl_o[15:0]), 64'(16'h1000));
    drive_src(32'h0);
    chk("R9 none", 64'(cpu_lvl_o[15:0]), 0);
  endtask

  task automatic t_target();
    logic [31:0] d;
    drive_src(32'h4000_0080);
    wr(4, 32'h0000_0006);
    rd(4, d); chk("R5 tgt masked", d, 2);
    chk("R7 cpu2 only", 64'(cpu_lvl_o), 64'(16'h8004) << 32);
    check_out("R7 model");
    wr(4, 32'hFFFF_FFFD);
    rd(4, d); chk("R5 tgt 1", d, 1);
    check_out("R7 cpu1");
  endtask

  task automatic t_ignored();
    logic [31:0] d;
    wr(3, 32'h0000_0100);
    wr(0, 32'hFFFF_FFFF);
    wr(1, 32'hFFFF_FFFF);
    wr(5, 32'hFFFF_FFFF);
    wr(7, 32'h0000_0003);
    rd(1, d); chk("R10 dis kept", d, 32'h0000_0100);
    rd(4, d); chk("R10 tgt kept", d, 1);
    rd(6, d); chk("R10 unused read", d, 0);
    @(negedge clk); reg_idx = 3'd4; #1 chk("R10 no strobe", reg_rdata, 0);
    check_out("R10 out");
  endtask

  task automatic t_master();
    drive_src(32'h7000_FF80);
    wr(3, 32'h8000_0000);
    chk("R8 kill on", 64'(master_off_o), 1);
    chk("R8 silenced", 64'(cpu_lvl_o), 0);
    wr(2, 32'h8000_0000);
    chk("R8 kill off", 64'(master_off_o), 0);
    check_out("R8 restored");
  endtask

  initial begin
    m_dis = STUCK; m_tgt = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_pending();
    t_masks();
    t_table();
    t_shared();
    t_target();
    t_ignored();
    t_master();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule